// File: doc/BRIEF.md
# Field Value Stream Receiver

This block sits on the receive side of a wide word stream that carries magnetic field measurements. The stream marks the start and end of each frame, and the block turns every complete frame into one held 32-bit field value. The signed value is taken from the low bits of the frame's opening word. The block stores it only once the frame's closing word has arrived.

The held value is given in offset-binary form, with zero field shown as the mid-scale code. A sticky flag shows whether any value has arrived since reset. A one-cycle strobe marks each cycle in which a newly committed value first appears. The block always accepts stream words and tells the stream so through its request output.

Top module: `bfield_stream_rx`

## Requirements
- R1: `rx_req` is 0 while `rst_n` is 0 and 1 whenever `rst_n` is 1.
- R2: After reset, `field_out` is 32'h8000_0000, `field_valid` is 0 and `field_upd` is 0.
- R3: A committed value appears on `field_out` as bits [31:0] of the opening word with bit 31 inverted. This is the two's complement value plus 2^31, without overflow. Bits above bit 31 of any word have no effect.
- R4: `field_valid` becomes 1 in the same cycle as the first commit and stays 1 until reset.
- R5: `field_upd` is 1 for exactly the one cycle after the clock edge that accepts a frame's closing word. It also pulses when the new value equals the held one.
- R6: A frame opens on a word with `rx_valid` and `rx_first` both 1. Its value comes from that word. The value is committed only at the word with `rx_valid` and `rx_last` both 1. `field_out` does not change while the frame is still open.
- R7: An opening word that arrives while a frame is still open discards that frame. The new word starts a fresh frame, and the discarded value never reaches `field_out`.
- R8: A single word with `rx_first` and `rx_last` both set forms a whole frame and commits its value.
- R9: A word with `rx_valid` at 0 has no effect. A closing word that arrives while no frame is open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_word | input | WORD_W (208) | Stream data word |
| rx_valid | input | 1 | Word present this cycle |
| rx_first | input | 1 | Word opens a frame |
| rx_last | input | 1 | Word closes a frame |
| rx_req | output | 1 | Request for more words |
| field_out | output | VAL_W (32) | Held field value, offset binary |
| field_valid | output | 1 | A value has been received since reset |
| field_upd | output | 1 | One-cycle strobe when a new value appears |

## Verification
The state that can go wrong is the open-frame flag and the captured value. If the flag is wrong, a stray closing word makes `field_upd` pulse, or a real closing word fails to pulse it. Either shows one cycle after that word. If the captured value is stale or taken from the wrong word, `field_out` shows a value that was discarded or a closing word's bits, also on the cycle after the close. The bench therefore checks `field_out` and `field_upd` on that exact cycle and again one cycle later, for every frame shape.

// File: rtl/bfield_stream_rx.sv
module bfield_stream_rx #(
  parameter int WORD_W = 208,
  parameter int VAL_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic              rx_last,
  output logic              rx_req,
  output logic [VAL_W-1:0]  field_out,
  output logic              field_valid,
  output logic              field_upd
);
  localparam logic [VAL_W-1:0] MID_CODE = {1'b1, {(VAL_W-1){1'b0}}};

  logic             open_q;
  logic [VAL_W-1:0] cap_q;

  wire             take   = rx_valid & rst_n;
  wire [VAL_W-1:0] low    = rx_word[VAL_W-1:0];
  wire             commit = take & rx_last & (rx_first | open_q);
  wire [VAL_W-1:0] src    = rx_first ? low : cap_q;

  assign rx_req = rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      cap_q       <= '0;
      field_out   <= MID_CODE;
      field_valid <= 1'b0;
      field_upd   <= 1'b0;
    end else begin
      field_upd <= commit;
      if (commit) begin
        field_out   <= src ^ MID_CODE;
        field_valid <= 1'b1;
      end
      if (take) begin
        if (rx_first) cap_q <= low;
        if (rx_first | rx_last) open_q <= rx_first & ~rx_last;
      end
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    field_valid |=> field_valid);  // R4
  AST_UPD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    field_upd |-> field_valid);  // R4
  AST_CHANGE_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_out) |-> field_upd);  // R6
  AST_UPD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    field_upd |-> $past(rx_valid && rx_last));  // R5
  AST_SINGLE_ENCODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && rx_valid && rx_first && rx_last) |->
      field_out == {~$past(rx_word[VAL_W-1]), $past(rx_word[VAL_W-2:0])});  // R3
  AST_REQ_OUT_OF_RESET: assert property (@(posedge clk)
    rst_n |-> rx_req);  // R1
endmodule

// File: tb/bfield_stream_rx_tb_top.sv
module bfield_stream_rx_tb_top;
  localparam int WORD_W = 208;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WORD_W-1:0] rx_word = '0;
  logic              rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0;
  logic              rx_req;
  logic [31:0]       field_out;
  logic              field_valid, field_upd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bfield_stream_rx #(.WORD_W(WORD_W), .VAL_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_first(rx_first), .rx_last(rx_last), .rx_req(rx_req),
    .field_out(field_out), .field_valid(field_valid), .field_upd(field_upd));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] mk(input logic [31:0] v, input logic [31:0] junk);
    logic [WORD_W-1:0] w;
    w = {(WORD_W/32+1){junk}};
    w[31:0] = v;
    return w;
  endfunction

  task automatic put(input logic [WORD_W-1:0] w, input bit vld, input bit f, input bit l);
    @(negedge clk);
    rx_word = w; rx_valid = vld; rx_first = f; rx_last = l;
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0; rx_word = '0;
  endtask

  task automatic expect_commit(input logic [31:0] v, input string req);
    chk(field_upd == 1'b1, req, {31'd0, field_upd}, 32'd1);
    chk(field_out == (v ^ 32'h8000_0000), req, field_out, v ^ 32'h8000_0000);
    chk(field_valid == 1'b1, "R4", {31'd0, field_valid}, 32'd1);
    @(negedge clk);
    chk(field_upd == 1'b0, "R5", {31'd0, field_upd}, 32'd0);
  endtask

  task automatic expect_quiet(input logic [31:0] held, input string req);
    chk(field_upd == 1'b0, req, {31'd0, field_upd}, 32'd0);
    chk(field_out == held, req, field_out, held);
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(rx_req == 1'b0, "R1", {31'd0, rx_req}, 32'd0);
    chk(field_out == 32'h8000_0000, "R2", field_out, 32'h8000_0000);
    chk(field_valid == 1'b0, "R2", {31'd0, field_valid}, 32'd0);
    chk(field_upd == 1'b0, "R2", {31'd0, field_upd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_req == 1'b1, "R1", {31'd0, rx_req}, 32'd1);
    // R9: a closing word with no open frame and a marked word without valid change nothing
    put(mk(32'h1234_5678, 32'hFFFF_FFFF), 1'b1, 1'b0, 1'b1);
    expect_quiet(32'h8000_0000, "R9");
    chk(field_valid == 1'b0, "R9", {31'd0, field_valid}, 32'd0);
    put(mk(32'h1234_5678, 32'h0), 1'b0, 1'b1, 1'b1);
    expect_quiet(32'h8000_0000, "R9");
    // R8 / R3: single-word frames, walking ones and specials, with junk upper bits
    for (int i = 0; i < 32; i++) begin
      put(mk(32'h1 << i, ~(32'h1 << i)), 1'b1, 1'b1, 1'b1);
      expect_commit(32'h1 << i, "R8");
    end
    put(mk(32'h0, 32'hFFFF_FFFF), 1'b1, 1'b1, 1'b1);
    expect_commit(32'h0, "R3");
    put(mk(32'hFFFF_FFFF, 32'h0), 1'b1, 1'b1, 1'b1);
    expect_commit(32'hFFFF_FFFF, "R3");
    put(mk(32'h7FFF_FFFF, 32'hA5A5_A5A5), 1'b1, 1'b1, 1'b1);
    expect_commit(32'h7FFF_FFFF, "R3");
    put(mk(32'h8000_0000, 32'h5A5A_5A5A), 1'b1, 1'b1, 1'b1);
    expect_commit(32'h8000_0000, "R3");
    // R5: same value again still pulses
    put(mk(32'h8000_0000, 32'h0), 1'b1, 1'b1, 1'b1);
    expect_commit(32'h8000_0000, "R5");
    // R6: multi-word frame, value from opening word, held until close
    for (int n = 1; n <= 4; n++) begin
      logic [31:0] v;
      v = 32'hC0DE_0000 + n * 32'h1111;
      held = field_out;
      put(mk(v, 32'h0), 1'b1, 1'b1, 1'b0);
      expect_quiet(held, "R6");
      for (int k = 0; k < n; k++) begin
        put(mk(32'hDEAD_0000 + k, 32'h0), 1'b1, 1'b0, 1'b0);
        expect_quiet(held, "R6");
      end
      put(mk(32'hBAD0_BAD0, 32'h0), 1'b0, 1'b0, 1'b1);
      expect_quiet(held, "R9");
      put(mk(32'h0BAD_F00D, 32'h0), 1'b1, 1'b0, 1'b1);
      expect_commit(v, "R6");
    end
    // R7: restart discards the first frame
    held = field_out;
    put(mk(32'h1111_1111, 32'h0), 1'b1, 1'b1, 1'b0);
    put(mk(32'h2222_2222, 32'h0), 1'b1, 1'b0, 1'b0);
    put(mk(32'h3333_3333, 32'h0), 1'b1, 1'b1, 1'b0);
    expect_quiet(held, "R7");
    put(mk(32'h4444_4444, 32'h0), 1'b1, 1'b0, 1'b1);
    expect_commit(32'h3333_3333, "R7");
    // R7/R8: open frame overtaken by a single-word frame
    put(mk(32'h5555_5555, 32'h0), 1'b1, 1'b1, 1'b0);
    put(mk(32'h6666_6666, 32'h0), 1'b1, 1'b1, 1'b1);
    expect_commit(32'h6666_6666, "R7");
    // R9: after the close, a lone closing word does nothing
    put(mk(32'h7777_7777, 32'h0), 1'b1, 1'b0, 1'b1);
    expect_quiet(32'h6666_6666 ^ 32'h8000_0000, "R9");
    chk(field_valid == 1'b1, "R4", {31'd0, field_valid}, 32'd1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule